// File: doc/BRIEF.md
# Phase-Stepped Instruction Sequencer

This block is the hardwired control state machine of a small accumulator machine with 16-bit instruction words. The upper four bits of each instruction word hold the operation and the lower twelve bits hold an address operand. A free-running eight-phase pulse generator steps the controller. Each state waits for one specific phase pulse before it moves on. The controller walks through a one-time program-counter clear, then a fixed instruction fetch, then a decode pause, and finally dispatches on the opcode.

Outputs are register-transfer strobes for the surrounding datapath, one wire per action. Each strobe is high for the single clock in which the phase pulse that ends its state is present. At most one strobe is active in any clock. Jump, conditional jump, switch load, halt and subroutine call are handled by dedicated states. All arithmetic, logic, memory and I/O opcodes share one generic execute state. A subroutine call takes two instruction cycles. Its second cycle loads the operand into both the buffer register and the program counter, and then rejoins the fetch at the memory-read step.

Top module: `fde_ctrl`

## Requirements
- R1: While rst_n is low, every bit of ctl_o is 0. In the first clock after release, only ctl_o[0] (clear program counter) is high. It stays high for exactly that one clock, and no strobe follows until the next CP1.
- R2: Fetch runs on phase_i[0..5] (CP1..CP6) with these strobes. CP1 gives ctl_o[1] (address register from program counter). CP2 gives ctl_o[2] (memory read into buffer). CP3 gives no strobe. CP4 gives ctl_o[3] (program counter increment). CP5 gives ctl_o[4] (instruction register from buffer). CP6 gives no strobe.
- R3: A phase pulse other than the one the current state waits for produces no strobe and does not advance the state.
- R4: opcode_i is decoded as 0 halt, 1 jump-if-negative, 2 jump, 3 subroutine call, 4 switch load, 5 to 14 generic operations, 15 no-op. It is sampled only at CP7 (phase_i[6]), which gives no strobe. Later changes of opcode_i or acc_sign_i do not alter the dispatched action.
- R5: A halt opcode raises ctl_o[6] (halt request) at CP8 (phase_i[7]), and fetch then restarts at CP1.
- R6: A no-op opcode produces no strobe at CP8, and fetch then restarts at CP1.
- R7: A jump opcode raises ctl_o[5] (program counter from operand) at CP8.
- R8: The jump-if-negative opcode raises ctl_o[5] at CP8 when acc_sign_i was 1 at CP7. When acc_sign_i was 0 at CP7, it gives no strobe at CP8.
- R9: A switch-load opcode raises ctl_o[7] (accumulator from switches) at CP8.
- R10: A subroutine call raises ctl_o[8] (accumulator from program counter) at CP8. At the following CP1 it raises ctl_o[9] (buffer and program counter from operand) instead of ctl_o[1]. The next CP2 then gives ctl_o[2].
- R11: Each of opcodes 5 to 14 raises ctl_o[10] (generic execute) at CP8, and fetch then restarts at CP1.
- R12: At most one bit of ctl_o is high in any clock, and no strobe lasts longer than one clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_i | input | 8 | One-hot phase pulses, bit k is CP(k+1) |
| opcode_i | input | OPC_W (4) | Operation field of the instruction register |
| acc_sign_i | input | 1 | Accumulator most significant bit |
| ctl_o | output | 11 | One-hot register-transfer strobes |

## Verification
The bench builds the block with the default OPC_W of 4. With that width, the whole opcode space of sixteen codes can be driven directly, so each dispatch target is reached, every one of the ten generic opcodes included. Phase pulses are driven one clock at a time, with deliberately misplaced pulses mixed in. This exposes whether a state advances only on its own phase and whether decode latches its inputs at CP7.

// File: rtl/fde_ctrl_pkg.sv
package fde_ctrl_pkg;

   localparam int NUM_PHASE  = 8;
   localparam int NUM_STROBE = 11;

   // phase pulse positions
   localparam int PH_CP1 = 0;
   localparam int PH_CP2 = 1;
   localparam int PH_CP3 = 2;
   localparam int PH_CP4 = 3;
   localparam int PH_CP5 = 4;
   localparam int PH_CP6 = 5;
   localparam int PH_CP7 = 6;
   localparam int PH_CP8 = 7;

   // strobe positions on ctl_o
   localparam int SB_CLR_PC = 0;
   localparam int SB_MAR_LD = 1;
   localparam int SB_MEM_RD = 2;
   localparam int SB_PC_INC = 3;
   localparam int SB_IR_LD  = 4;
   localparam int SB_PC_JMP = 5;
   localparam int SB_HALT   = 6;
   localparam int SB_ACC_SW = 7;
   localparam int SB_ACC_PC = 8;
   localparam int SB_OPR_LD = 9;
   localparam int SB_EXEC   = 10;

   // opcode values with dedicated handling
   localparam int OP_HLT = 0;
   localparam int OP_JMA = 1;
   localparam int OP_JMP = 2;
   localparam int OP_JSR = 3;
   localparam int OP_CSA = 4;
   localparam int OP_NOP = 15;

   typedef enum logic [3:0] {
      ST_RESET,
      ST_F0,
      ST_F1,
      ST_F2,
      ST_F3,
      ST_F4,
      ST_DEC,
      ST_HLT,
      ST_WAIT,
      ST_JMP,
      ST_CSA,
      ST_JSR1,
      ST_JSR2,
      ST_EXEC
   } seq_state_t;

endpackage

// File: rtl/fde_op_decoder.sv
module fde_op_decoder #(
   parameter int OPC_W = 4
) (
   input  logic [OPC_W-1:0]      opcode_i,
   output logic [(1<<OPC_W)-1:0] onehot_o
);
   localparam int NUM_OPS = 1 << OPC_W;

   generate
      for (genvar g = 0; g < NUM_OPS; g++) begin : g_line
         assign onehot_o[g] = (opcode_i == OPC_W'(g));
      end
   endgenerate

endmodule

// File: rtl/fde_phase_seq.sv
module fde_phase_seq
   import fde_ctrl_pkg::*;
#(
   parameter int OPC_W = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_PHASE-1:0]     phase_i,
   input  logic [(1<<OPC_W)-1:0]    op_onehot_i,
   input  logic                     acc_sign_i,
   output seq_state_t               state_o
);
   localparam int NUM_OPS = 1 << OPC_W;
   localparam logic [NUM_OPS-1:0] DEDICATED =
      (NUM_OPS'(1) << OP_HLT) | (NUM_OPS'(1) << OP_JMA) |
      (NUM_OPS'(1) << OP_JMP) | (NUM_OPS'(1) << OP_JSR) |
      (NUM_OPS'(1) << OP_CSA) | (NUM_OPS'(1) << OP_NOP);

   seq_state_t state_q, state_d, dispatch;
   logic       is_generic;

   assign is_generic = |(op_onehot_i & ~DEDICATED);

   // target chosen when the decode pause ends
   always_comb begin
      dispatch = ST_WAIT;
      if (op_onehot_i[OP_HLT])      dispatch = ST_HLT;
      else if (op_onehot_i[OP_JMP]) dispatch = ST_JMP;
      else if (op_onehot_i[OP_JMA]) dispatch = acc_sign_i ? ST_JMP : ST_WAIT;
      else if (op_onehot_i[OP_CSA]) dispatch = ST_CSA;
      else if (op_onehot_i[OP_JSR]) dispatch = ST_JSR1;
      else if (is_generic)          dispatch = ST_EXEC;
      else if (op_onehot_i[OP_NOP]) dispatch = ST_WAIT;
   end

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_RESET: state_d = ST_F0;
         ST_F0:    if (phase_i[PH_CP1]) state_d = ST_F1;
         ST_F1:    if (phase_i[PH_CP2]) state_d = ST_F2;
         ST_F2:    if (phase_i[PH_CP3]) state_d = ST_F3;
         ST_F3:    if (phase_i[PH_CP4]) state_d = ST_F4;
         ST_F4:    if (phase_i[PH_CP5]) state_d = ST_DEC;
         ST_DEC:   if (phase_i[PH_CP7]) state_d = dispatch;
         ST_HLT, ST_WAIT, ST_JMP, ST_CSA, ST_EXEC:
                   if (phase_i[PH_CP8]) state_d = ST_F0;
         ST_JSR1:  if (phase_i[PH_CP8]) state_d = ST_JSR2;
         ST_JSR2:  if (phase_i[PH_CP1]) state_d = ST_F1;
         default:  state_d = ST_RESET;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_RESET;
      else        state_q <= state_d;
   end

   assign state_o = state_q;

   assert_reset_exit_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RESET) |=> (state_q == ST_F0));

   assert_hold_in_f0_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_F0 && !phase_i[PH_CP1]) |=> (state_q == ST_F0));

   assert_hold_in_dec_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_DEC && !phase_i[PH_CP7]) |=> (state_q == ST_DEC));

   assert_jma_positive_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_DEC && phase_i[PH_CP7] && op_onehot_i[OP_JMA] && !acc_sign_i)
      |=> (state_q == ST_WAIT));

   assert_jsr_rejoin_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_JSR2 && phase_i[PH_CP1]) |=> (state_q == ST_F1));

endmodule

// File: rtl/fde_strobe_gen.sv
module fde_strobe_gen
   import fde_ctrl_pkg::*;
(
   input  seq_state_t              state_i,
   input  logic [NUM_PHASE-1:0]    phase_i,
   output logic [NUM_STROBE-1:0]   strobe_o
);
   always_comb begin
      strobe_o = '0;
      unique case (state_i)
         ST_RESET: strobe_o[SB_CLR_PC] = 1'b1;
         ST_F0:    strobe_o[SB_MAR_LD] = phase_i[PH_CP1];
         ST_F1:    strobe_o[SB_MEM_RD] = phase_i[PH_CP2];
         ST_F3:    strobe_o[SB_PC_INC] = phase_i[PH_CP4];
         ST_F4:    strobe_o[SB_IR_LD]  = phase_i[PH_CP5];
         ST_HLT:   strobe_o[SB_HALT]   = phase_i[PH_CP8];
         ST_JMP:   strobe_o[SB_PC_JMP] = phase_i[PH_CP8];
         ST_CSA:   strobe_o[SB_ACC_SW] = phase_i[PH_CP8];
         ST_JSR1:  strobe_o[SB_ACC_PC] = phase_i[PH_CP8];
         ST_JSR2:  strobe_o[SB_OPR_LD] = phase_i[PH_CP1];
         ST_EXEC:  strobe_o[SB_EXEC]   = phase_i[PH_CP8];
         default:  strobe_o = '0;
      endcase
   end

endmodule

// File: rtl/fde_ctrl.sv
module fde_ctrl
   import fde_ctrl_pkg::*;
#(
   parameter int OPC_W = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NUM_PHASE-1:0]    phase_i,
   input  logic [OPC_W-1:0]        opcode_i,
   input  logic                    acc_sign_i,
   output logic [NUM_STROBE-1:0]   ctl_o
);
   localparam int NUM_OPS = 1 << OPC_W;

   generate
      if (OPC_W < 4 || OPC_W > 8) begin : g_bad_width
         $error("fde_ctrl: OPC_W must lie between 4 and 8");
      end
   endgenerate

   logic [NUM_OPS-1:0]    op_onehot;
   seq_state_t            state;
   logic [NUM_STROBE-1:0] strobe;

   fde_op_decoder #(.OPC_W(OPC_W)) u_dec (
      .opcode_i (opcode_i),
      .onehot_o (op_onehot)
   );

   fde_phase_seq #(.OPC_W(OPC_W)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .phase_i     (phase_i),
      .op_onehot_i (op_onehot),
      .acc_sign_i  (acc_sign_i),
      .state_o     (state)
   );

   fde_strobe_gen u_stb (
      .state_i  (state),
      .phase_i  (phase_i),
      .strobe_o (strobe)
   );

   assign ctl_o = rst_n ? strobe : '0;

   assert_single_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ctl_o));

   assert_clear_once_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_o[SB_CLR_PC] |=> !ctl_o[SB_CLR_PC]);

   assert_mar_on_cp1_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_o[SB_MAR_LD] |-> phase_i[PH_CP1]);

   assert_ir_on_cp5_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_o[SB_IR_LD] |-> phase_i[PH_CP5]);

   assert_halt_on_cp8_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_o[SB_HALT] |-> phase_i[PH_CP8]);

   assert_exec_on_cp8_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_o[SB_EXEC] |-> phase_i[PH_CP8]);

endmodule

// File: tb/fde_ctrl_bench.sv
module fde_ctrl_bench;

   localparam logic [10:0] NONE   = 11'd0;
   localparam logic [10:0] CLR    = 11'b1 << 0;
   localparam logic [10:0] MAR    = 11'b1 << 1;
   localparam logic [10:0] RD     = 11'b1 << 2;
   localparam logic [10:0] INC    = 11'b1 << 3;
   localparam logic [10:0] IRL    = 11'b1 << 4;
   localparam logic [10:0] PCJ    = 11'b1 << 5;
   localparam logic [10:0] HLT    = 11'b1 << 6;
   localparam logic [10:0] ACCSW  = 11'b1 << 7;
   localparam logic [10:0] ACCPC  = 11'b1 << 8;
   localparam logic [10:0] OPRLD  = 11'b1 << 9;
   localparam logic [10:0] EXE    = 11'b1 << 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  phase_i = 8'd0;
   logic [3:0]  opcode_i = 4'd15;
   logic        acc_sign_i = 1'b0;
   logic [10:0] ctl_o;

   logic [3:0]  drv_opc = 4'd15;
   logic        drv_acc = 1'b0;
   logic [10:0] obs;
   int          n_total = 0;
   int          n_fail  = 0;

   always #5 clk = ~clk;

   fde_ctrl u_fde_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .phase_i    (phase_i),
      .opcode_i   (opcode_i),
      .acc_sign_i (acc_sign_i),
      .ctl_o      (ctl_o)
   );

   // one clock with phase k (k < 0: no pulse); inputs change at the falling edge
   task automatic pulse(input int k);
      @(negedge clk);
      phase_i    = (k < 0) ? 8'd0 : (8'd1 << k);
      opcode_i   = drv_opc;
      acc_sign_i = drv_acc;
      #1;
      obs = ctl_o;
   endtask

   task automatic chk(input logic [10:0] exp, input string req, input string what);
      n_total++;
      if (obs !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%b expected=%b", req, what, obs, exp);
      end
   endtask

   task automatic fetch(input string req);
      pulse(0); chk(MAR, req, "CP1 address load");
      pulse(1); chk(RD,  req, "CP2 memory read");
      pulse(2); chk(NONE, req, "CP3 wait");
      pulse(3); chk(INC, req, "CP4 increment");
      pulse(4); chk(IRL, req, "CP5 instruction load");
      pulse(5); chk(NONE, req, "CP6 decode pause");
   endtask

   task automatic dispatch(input logic [3:0] opc, input logic acc,
                           input logic [10:0] exp8, input string req);
      drv_opc = opc; drv_acc = acc;
      pulse(6); chk(NONE, "R4", "CP7 gives no strobe");
      pulse(7); chk(exp8, req, "CP8 action");
   endtask

   task automatic t_reset();
      repeat (3) @(posedge clk);
      @(negedge clk); #1; obs = ctl_o;
      chk(NONE, "R1", "quiet during reset");
      @(negedge clk); rst_n = 1'b1; #1; obs = ctl_o;
      chk(CLR, "R1", "clear after release");
      pulse(-1); chk(NONE, "R1", "clear lasts one clock");
      pulse(-1); chk(NONE, "R1", "no strobe before CP1");
   endtask

   task automatic t_nop();
      fetch("R2");
      dispatch(4'd15, 1'b0, NONE, "R6");
      pulse(-1); chk(NONE, "R12", "idle after no-op");
   endtask

   task automatic t_ignore();
      pulse(2); chk(NONE, "R3", "CP3 ignored in first fetch state");
      pulse(7); chk(NONE, "R3", "CP8 ignored in first fetch state");
      pulse(0); chk(MAR, "R3", "CP1 still accepted");
      pulse(0); chk(NONE, "R3", "repeated CP1 ignored");
      pulse(1); chk(RD, "R3", "CP2 after stray pulse");
      pulse(2); chk(NONE, "R3", "CP3");
      pulse(0); chk(NONE, "R3", "CP1 ignored before increment");
      pulse(3); chk(INC, "R3", "CP4 after stray pulse");
      pulse(4); chk(IRL, "R3", "CP5");
      drv_opc = 4'd11;
      pulse(7); chk(NONE, "R3", "CP8 ignored before dispatch");
      dispatch(4'd11, 1'b0, EXE, "R3");
   endtask

   task automatic t_late_change();
      fetch("R2");
      drv_opc = 4'd2; drv_acc = 1'b0;
      pulse(6); chk(NONE, "R4", "dispatch jump");
      drv_opc = 4'd0;
      pulse(7); chk(PCJ, "R4", "opcode change after CP7 ignored");
      fetch("R2");
      drv_opc = 4'd1; drv_acc = 1'b1;
      pulse(6); chk(NONE, "R4", "dispatch conditional");
      drv_acc = 1'b0;
      pulse(7); chk(PCJ, "R4", "sign change after CP7 ignored");
   endtask

   task automatic t_halt();
      fetch("R2");
      dispatch(4'd0, 1'b0, HLT, "R5");
      pulse(-1); chk(NONE, "R12", "halt lasts one clock");
      pulse(0); chk(MAR, "R5", "fetch resumes after halt");
      pulse(1); pulse(2); pulse(3); pulse(4); pulse(5);
      dispatch(4'd15, 1'b0, NONE, "R6");
   endtask

   task automatic t_jumps();
      fetch("R2");
      dispatch(4'd2, 1'b0, PCJ, "R7");
      fetch("R2");
      dispatch(4'd1, 1'b1, PCJ, "R8");
      fetch("R2");
      dispatch(4'd1, 1'b0, NONE, "R8");
      fetch("R2");
      dispatch(4'd2, 1'b1, PCJ, "R7");
   endtask

   task automatic t_csa();
      fetch("R2");
      dispatch(4'd4, 1'b1, ACCSW, "R9");
   endtask

   task automatic t_jsr();
      fetch("R2");
      dispatch(4'd3, 1'b0, ACCPC, "R10");
      pulse(-1); chk(NONE, "R10", "idle between call cycles");
      pulse(1); chk(NONE, "R10", "CP2 ignored before operand load");
      pulse(0); chk(OPRLD, "R10", "CP1 operand load, not address load");
      pulse(1); chk(RD, "R10", "rejoin at memory read");
      pulse(2); chk(NONE, "R10", "CP3");
      pulse(3); chk(INC, "R10", "CP4");
      pulse(4); chk(IRL, "R10", "CP5");
      pulse(5); chk(NONE, "R10", "CP6");
      dispatch(4'd15, 1'b0, NONE, "R6");
   endtask

   task automatic t_generic();
      for (int op = 5; op <= 14; op++) begin
         fetch("R2");
         dispatch(4'(op), op[0], EXE, "R11");
      end
      pulse(-1); chk(NONE, "R12", "execute strobe lasts one clock");
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_total++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
   end

   initial begin
      t_reset();
      t_nop();
      t_ignore();
      t_late_change();
      t_halt();
      t_jumps();
      t_csa();
      t_jsr();
      t_generic();
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
   end

endmodule